// File: doc/BRIEF.md
# Low-Side Channel Fault Monitor

This block watches a bank of low-side switch channels for two fault kinds: an open load and a short circuit. For each channel it takes two raw detector bits and the commanded switch state. The open detector is trusted only while the switch is commanded open. The short detector is trusted only while the switch is commanded closed. A detector bit counts only after it has passed a two-flop synchronizer and then stayed high for a set number of consecutive slow ticks. The slow tick is a divided version of the block clock at the detector sampling rate.

The open flag reports a condition that is present now, and it drops as soon as that condition goes away. The short flag latches. It produces a per-channel disable that the PWM stage uses to force the channel off. Software removes latched shorts with a global clear strobe. The strobe has no effect on any channel that is being commanded closed at that moment. A per-channel report-disable input stops shorts from being flagged on that channel and stops them from disabling it. This is needed at very low current settings, where the detector gives false shorts. A synchronized supply-good input drives the module-present indication.

Top module: `lsfault_monitor`

## Requirements
- R1: An open flag sets only after the synchronized open detector has been high, with the switch commanded open (swCmd bit 0), for QUAL_TICKS consecutive slow ticks (default 4; one tick every TICK_DIV clocks). A pulse shorter than two tick periods sets nothing.
- R2: An open flag clears by itself within four clocks after the raw open detector goes low.
- R3: While a channel is commanded closed (swCmd bit 1), its open detector is ignored and its open flag reads 0.
- R4: A short flag sets after the synchronized short detector has been high for QUAL_TICKS consecutive ticks while the switch is commanded closed. Once set, it stays set after the detector goes low.
- R5: While a channel is commanded open, its short detector is ignored and its short flag does not set.
- R6: chanDisable of a channel equals its short flag ANDed with the inverse of its report-disable bit.
- R7: A one-clock pulse on shortClear clears the short flags of all channels that are commanded open in that clock.
- R8: shortClear leaves the short flag of any channel that is commanded closed in that clock unchanged.
- R9: A channel whose shortRptDis bit is 1 never gets a new short flag.
- R10: After reset, all open flags, short flags, disables and modulePresent are 0.
- R11: modulePresent follows supplyGood through a two-flop synchronizer, with two clocks of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swCmd | input | NUM_CHAN | Commanded switch state per channel, 1 = closed |
| openRaw | input | NUM_CHAN | Raw open-load detector bits |
| shortRaw | input | NUM_CHAN | Raw short-circuit detector bits |
| shortRptDis | input | NUM_CHAN | Per-channel short report disable |
| shortClear | input | 1 | Global short-flag clear strobe |
| supplyGood | input | 1 | External supply good indication |
| openFlag | output | NUM_CHAN | Open-load flags, self-clearing |
| shortFlag | output | NUM_CHAN | Latched short-circuit flags |
| chanDisable | output | NUM_CHAN | Per-channel PWM gate-off |
| modulePresent | output | 1 | Synchronized supply-good |

## Verification
The assertions assume that swCmd and shortRptDis are driven synchronously to clk. They also assume that shortClear is sampled in the same clock as swCmd, so the "commanded closed" test for a clear uses the same value the flags see. The stimulus changes every input only on the falling edge. It holds each detector pattern for six tick periods, so that qualification has finished before outputs are sampled. Glitch tests use pulses of exactly two tick periods, which is inside the window that cannot reach four ticks.

// File: rtl/lsfault_pkg.sv
package lsfault_pkg;
  typedef struct packed {
    logic tick;      // one clock pulse per detector sampling tick
    logic clearAll;  // software short-clear request
  } lsfault_strobe_t;
endpackage

// File: rtl/lsfault_sync.sv
module lsfault_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= dIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/lsfault_ctrl.sv
module lsfault_ctrl
  import lsfault_pkg::*;
#(
  parameter int TICK_DIV = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            shortClear,
  output lsfault_strobe_t strobe
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe.tick     = (divCnt == LAST);
    strobe.clearAll = shortClear;
  end
endmodule

// File: rtl/lsfault_datapath.sv
module lsfault_datapath
  import lsfault_pkg::*;
#(
  parameter int NUM_CHAN   = 8,
  parameter int QUAL_TICKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsfault_strobe_t     strobe,
  input  logic [NUM_CHAN-1:0] swCmd,
  input  logic [NUM_CHAN-1:0] openRaw,
  input  logic [NUM_CHAN-1:0] shortRaw,
  input  logic [NUM_CHAN-1:0] shortRptDis,
  input  logic                supplyGood,
  output logic [NUM_CHAN-1:0] openFlag,
  output logic [NUM_CHAN-1:0] shortFlag,
  output logic [NUM_CHAN-1:0] chanDisable,
  output logic                modulePresent
);
  localparam int QW = $clog2(QUAL_TICKS) + 1;
  localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

  logic [NUM_CHAN-1:0] openSync, shortSync;

  lsfault_sync #(.WIDTH(NUM_CHAN)) u_openSync (
    .clk(clk), .rstN(rstN), .dIn(openRaw), .dOut(openSync));
  lsfault_sync #(.WIDTH(NUM_CHAN)) u_shortSync (
    .clk(clk), .rstN(rstN), .dIn(shortRaw), .dOut(shortSync));
  lsfault_sync #(.WIDTH(1)) u_supplySync (
    .clk(clk), .rstN(rstN), .dIn(supplyGood), .dOut(modulePresent));

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic [QW-1:0] openCnt, shortCnt;
    logic openCond, shortCond;

    assign openCond  = openSync[ch] & ~swCmd[ch];
    assign shortCond = shortSync[ch] & swCmd[ch] & ~shortRptDis[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openCnt      <= '0;
        openFlag[ch] <= 1'b0;
      end else if (!openCond) begin
        openCnt      <= '0;
        openFlag[ch] <= 1'b0;
      end else if (strobe.tick && !openFlag[ch]) begin
        if (openCnt == QLAST) openFlag[ch] <= 1'b1;
        else openCnt <= openCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shortCnt <= '0;
      end else if (!shortCond) begin
        shortCnt <= '0;
      end else if (strobe.tick && shortCnt != QLAST) begin
        shortCnt <= shortCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shortFlag[ch] <= 1'b0;
      end else if (strobe.clearAll && !swCmd[ch]) begin
        shortFlag[ch] <= 1'b0;
      end else if (shortCond && strobe.tick && shortCnt == QLAST) begin
        shortFlag[ch] <= 1'b1;
      end
    end

    assign chanDisable[ch] = shortFlag[ch] & ~shortRptDis[ch];
  end
endmodule

// File: rtl/lsfault_monitor.sv
module lsfault_monitor
  import lsfault_pkg::*;
#(
  parameter int NUM_CHAN   = 8,
  parameter int TICK_DIV   = 20,
  parameter int QUAL_TICKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CHAN-1:0] swCmd,
  input  logic [NUM_CHAN-1:0] openRaw,
  input  logic [NUM_CHAN-1:0] shortRaw,
  input  logic [NUM_CHAN-1:0] shortRptDis,
  input  logic                shortClear,
  input  logic                supplyGood,
  output logic [NUM_CHAN-1:0] openFlag,
  output logic [NUM_CHAN-1:0] shortFlag,
  output logic [NUM_CHAN-1:0] chanDisable,
  output logic                modulePresent
);
  lsfault_strobe_t strobe;

  lsfault_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .shortClear(shortClear), .strobe(strobe));

  lsfault_datapath #(.NUM_CHAN(NUM_CHAN), .QUAL_TICKS(QUAL_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swCmd(swCmd),
    .openRaw(openRaw), .shortRaw(shortRaw), .shortRptDis(shortRptDis),
    .supplyGood(supplyGood), .openFlag(openFlag), .shortFlag(shortFlag),
    .chanDisable(chanDisable), .modulePresent(modulePresent));
endmodule

// File: rtl/lsfault_checker.sv
module lsfault_checker #(
  parameter int NUM_CHAN = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CHAN-1:0] swCmd,
  input logic [NUM_CHAN-1:0] shortRptDis,
  input logic                shortClear,
  input logic [NUM_CHAN-1:0] openFlag,
  input logic [NUM_CHAN-1:0] shortFlag,
  input logic [NUM_CHAN-1:0] chanDisable
);
  assert_open_only_when_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(swCmd) & openFlag) == '0));

  assert_short_holds_closed_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(shortFlag & swCmd) & ~shortFlag) == '0));

  assert_no_short_set_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((shortFlag & ~$past(shortFlag) & ~$past(swCmd)) == '0));

  assert_rptdis_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((shortFlag & ~$past(shortFlag) & $past(shortRptDis)) == '0));

  assert_clear_open_chans_R7: assert property (@(posedge clk) disable iff (!rstN)
    shortClear |=> ((shortFlag & ~$past(swCmd)) == '0));

  assert_disable_needs_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((chanDisable & ~shortFlag) == '0));
endmodule

bind lsfault_monitor lsfault_checker #(.NUM_CHAN(NUM_CHAN)) u_checker (
  .clk(clk), .rstN(rstN), .swCmd(swCmd), .shortRptDis(shortRptDis),
  .shortClear(shortClear), .openFlag(openFlag), .shortFlag(shortFlag),
  .chanDisable(chanDisable));

// File: tb/lsfault_monitor_bench.sv
module lsfault_monitor_bench;
  localparam int N    = 8;
  localparam int DIV  = 20;
  localparam int HOLD = 6 * DIV;
  localparam int NVEC = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] swCmd = '0, openRaw = '0, shortRaw = '0, shortRptDis = '0;
  logic shortClear = 1'b0, supplyGood = 1'b0;
  logic [N-1:0] openFlag, shortFlag, chanDisable;
  logic modulePresent;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lsfault_monitor #(.NUM_CHAN(N), .TICK_DIV(DIV), .QUAL_TICKS(4)) u_lsfault_monitor (
    .clk(clk), .rstN(rstN), .swCmd(swCmd), .openRaw(openRaw),
    .shortRaw(shortRaw), .shortRptDis(shortRptDis), .shortClear(shortClear),
    .supplyGood(supplyGood), .openFlag(openFlag), .shortFlag(shortFlag),
    .chanDisable(chanDisable), .modulePresent(modulePresent));

  // {swCmd, openRaw, shortRaw, rptDis, expOpen, expShort}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'h0F, 8'h00, 8'h00, 8'h0F, 8'h00},  // R1
    {8'h03, 8'h0F, 8'h00, 8'h00, 8'h0C, 8'h00},  // R3
    {8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},  // R2
    {8'hF0, 8'h00, 8'h30, 8'h20, 8'h00, 8'h10},  // R4 R9
    {8'hF0, 8'h00, 8'h00, 8'h20, 8'h00, 8'h10},  // R4 latch
    {8'hF0, 8'h00, 8'h0C, 8'h20, 8'h00, 8'h10}   // R5
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    waitClk(100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitClk(3);
    check("R10 open", openFlag, '0);
    check("R10 short", shortFlag, '0);
    check("R10 disable", chanDisable, '0);
    check("R10 present", {7'd0, modulePresent}, '0);
    rstN = 1'b1;
    waitClk(2);

    // R11: two-clock latency
    supplyGood = 1'b1;
    waitClk(1);
    check("R11 early", {7'd0, modulePresent}, '0);
    waitClk(1);
    check("R11", {7'd0, modulePresent}, 8'h01);

    for (int v = 0; v < NVEC; v++) begin
      swCmd = VEC[v][47:40]; openRaw = VEC[v][39:32];
      shortRaw = VEC[v][31:24]; shortRptDis = VEC[v][23:16];
      waitClk(HOLD);
      check($sformatf("R1/R2/R3 open vec%0d", v), openFlag, VEC[v][15:8]);
      check($sformatf("R4/R5/R9 short vec%0d", v), shortFlag, VEC[v][7:0]);
      check($sformatf("R6 disable vec%0d", v), chanDisable, VEC[v][7:0] & ~VEC[v][23:16]);
    end
    shortRaw = '0;

    // R8: channel 4 closed, clear ignored
    shortClear = 1'b1; waitClk(1); shortClear = 1'b0; waitClk(1);
    check("R8", shortFlag, 8'h10);

    // R6: report disable masks an existing latched flag
    shortRptDis = 8'h10; waitClk(1);
    check("R6 masked", chanDisable, 8'h00);
    shortRptDis = 8'h00; waitClk(1);
    check("R6 unmasked", chanDisable, 8'h10);

    // R7: open all, then clear
    swCmd = 8'h00; waitClk(2);
    check("R7 before", shortFlag, 8'h10);
    shortClear = 1'b1; waitClk(1); shortClear = 1'b0; waitClk(1);
    check("R7", shortFlag, 8'h00);

    // R1: open pulse of two tick periods does not qualify
    openRaw = 8'h01; waitClk(2 * DIV); openRaw = 8'h00; waitClk(HOLD);
    check("R1 glitch", openFlag, 8'h00);

    // R4: short pulse of two tick periods does not qualify
    swCmd = 8'h01; shortRaw = 8'h01; waitClk(2 * DIV); shortRaw = 8'h00; waitClk(HOLD);
    check("R4 glitch", shortFlag, 8'h00);

    // R2: open flag drops within four clocks
    swCmd = 8'h00; openRaw = 8'h80; waitClk(HOLD);
    check("R2 set", openFlag, 8'h80);
    openRaw = 8'h00; waitClk(4);
    check("R2 drop", openFlag, 8'h00);

    // R3: closing the switch removes the open flag
    openRaw = 8'h40; waitClk(HOLD);
    check("R3 set", openFlag, 8'h40);
    swCmd = 8'h40; waitClk(1);
    check("R3 closed", openFlag, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule